// File: doc/BRIEF.md
# Complex-Multiply Instruction Handshake Wrapper

This block sits between a processor's auxiliary instruction port and a small multicycle engine that multiplies two complex numbers. The processor presents a decoded custom-instruction request together with two 32-bit operands. The wrapper captures the operands, runs the engine for a fixed number of cycles, and then returns one 32-bit result. On that same cycle it raises done and result-valid.

Each operand holds one complex number. The real part sits in the upper half and the imaginary part in the lower half, both as two's-complement values. The processor may give both operands on the same clock edge, or give the second operand on a later edge. The wrapper takes a new request in the very cycle it responds, so instructions can run back to back with no dead cycle between them.

Top module: `cplx_wrap_top`

## Requirements
- R1: While reset is asserted, and after it is released until a request is accepted, done and resultValid are 0 and result is 0. A reset during a computation discards that computation, so no response follows.
- R2: The operand encoding is: bits [31:16] hold the signed real part and bits [15:0] hold the signed imaginary part. For operands A and B, the result is {low 16 bits of (Are*Bre - Aim*Bim), low 16 bits of (Are*Bim + Aim*Bre)}.
- R3: When instrValid, opAValid and opBValid are all high on the same rising edge of an idle wrapper, the response is visible on the RUN_CYCLES-th rising edge after that one, and not before it.
- R4: When instrValid and opAValid are high without opBValid, the wrapper waits any number of cycles for opBValid. The response is visible RUN_CYCLES edges after the edge that samples opBValid. While it waits, changes on opA, instrValid and opAValid have no effect on the result.
- R5: done and resultValid rise together, stay high for exactly one cycle, and carry the result in that cycle. At all other times result is 0.
- R6: A request presented in the response cycle is accepted at the edge that ends that cycle, with operands given together or split. Its response follows with the same timing as in R3 and R4, with no idle cycle inserted.
- R7: opBValid high while the wrapper is idle and no request is being accepted is ignored. A later split request uses only the operand B delivered after its own operand A.
- R8: instrValid high without opAValid in the idle state is ignored: no response follows.
- R9: Request and operand inputs sampled while the engine is running are ignored and do not alter the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Decoded custom-instruction request |
| opAValid | input | 1 | Operand A present |
| opA | input | 32 | Operand A (real in upper half, imaginary in lower half) |
| opBValid | input | 1 | Operand B present |
| opB | input | 32 | Operand B (same encoding) |
| done | output | 1 | Instruction complete, one-cycle pulse |
| resultValid | output | 1 | Result word valid, one-cycle pulse |
| result | output | 32 | Packed complex product, 0 when not valid |

## Verification
The bench builds the wrapper with a 32-bit word and the default engine length of three cycles. This keeps each instruction short, so long chains of back-to-back requests fit in a small run. A three-cycle engine also lets the two product phases and the idle padding cycle all occur. Random requests mix same-edge and split operands, with gaps of zero to three cycles before operand B. Half of the requests are issued in the response cycle of the one before. Noise on every input is driven while the engine runs and while it waits for operand B. A reset in the middle of a computation is also covered.

// File: rtl/cplx_wrap_pkg.sv
package cplx_wrap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_B  = 2'd1,
    ST_RUN     = 2'd2,
    ST_RESPOND = 2'd3
  } wrapState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic stepRe;
    logic stepIm;
  } dpCtl_t;

endpackage

// File: rtl/cplx_wrap_ctrl.sv
module cplx_wrap_ctrl
  import cplx_wrap_pkg::*;
#(
  parameter int RUN_CYCLES = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   instrValid,
  input  logic   opAValid,
  input  logic   opBValid,
  output dpCtl_t dpCtl,
  output logic   respond,
  output logic   inRun
);

  localparam int CNT_W = $clog2(RUN_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RUN_CYCLES - 1);

  wrapState_t state, stateNext;
  logic [CNT_W-1:0] runCnt;
  logic takeReq;

  // a request may start only when the engine is free
  assign takeReq = instrValid && opAValid &&
                   ((state == ST_IDLE) || (state == ST_RESPOND));

  always_comb begin
    stateNext = state;
    dpCtl     = '0;
    unique case (state)
      ST_IDLE, ST_RESPOND: begin
        if (takeReq) begin
          dpCtl.loadA = 1'b1;
          if (opBValid) begin
            dpCtl.loadB = 1'b1;
            stateNext   = ST_RUN;
          end else begin
            stateNext = ST_WAIT_B;
          end
        end else begin
          stateNext = ST_IDLE;
        end
      end
      ST_WAIT_B: begin
        if (opBValid) begin
          dpCtl.loadB = 1'b1;
          stateNext   = ST_RUN;
        end
      end
      ST_RUN: begin
        dpCtl.stepRe = (runCnt == '0);
        dpCtl.stepIm = (runCnt == CNT_W'(1));
        if (runCnt == LAST_CNT) stateNext = ST_RESPOND;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      runCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_RUN) runCnt <= runCnt + CNT_W'(1);
      else                 runCnt <= '0;
    end
  end

  assign respond = (state == ST_RESPOND);
  assign inRun   = (state == ST_RUN);

endmodule

// File: rtl/cplx_wrap_dp.sv
module cplx_wrap_dp
  import cplx_wrap_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] resultWord
);

  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] regA, regB;
  logic signed [HALF_W-1:0] aRe, aIm, bRe, bIm;
  logic signed [HALF_W-1:0] mulX, mulY, partSum;
  logic [HALF_W-1:0] reRes, imRes;

  assign aRe = regA[WORD_W-1:HALF_W];
  assign aIm = regA[HALF_W-1:0];
  assign bRe = regB[WORD_W-1:HALF_W];
  assign bIm = regB[HALF_W-1:0];

  // two shared multipliers, low half only; phase picks the cross terms
  always_comb begin
    if (dpCtl.stepRe) begin
      mulX    = aRe * bRe;
      mulY    = aIm * bIm;
      partSum = mulX - mulY;
    end else begin
      mulX    = aRe * bIm;
      mulY    = aIm * bRe;
      partSum = mulX + mulY;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA  <= '0;
      regB  <= '0;
      reRes <= '0;
      imRes <= '0;
    end else begin
      if (dpCtl.loadA)  regA  <= opA;
      if (dpCtl.loadB)  regB  <= opB;
      if (dpCtl.stepRe) reRes <= partSum;
      if (dpCtl.stepIm) imRes <= partSum;
    end
  end

  assign resultWord = {reRes, imRes};

endmodule

// File: rtl/cplx_wrap_top.sv
module cplx_wrap_top
  import cplx_wrap_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int RUN_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic              opAValid,
  input  logic [WORD_W-1:0] opA,
  input  logic              opBValid,
  input  logic [WORD_W-1:0] opB,
  output logic              done,
  output logic              resultValid,
  output logic [WORD_W-1:0] result
);

  dpCtl_t dpCtl;
  logic ctlRespond, ctlInRun;
  logic [WORD_W-1:0] resultWord;

  cplx_wrap_ctrl #(.RUN_CYCLES(RUN_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrValid(instrValid),
    .opAValid  (opAValid),
    .opBValid  (opBValid),
    .dpCtl     (dpCtl),
    .respond   (ctlRespond),
    .inRun     (ctlInRun)
  );

  cplx_wrap_dp #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtl     (dpCtl),
    .opA       (opA),
    .opB       (opB),
    .resultWord(resultWord)
  );

  assign done        = ctlRespond;
  assign resultValid = ctlRespond;
  assign result      = ctlRespond ? resultWord : '0;

endmodule

// File: rtl/cplx_wrap_chk.sv
module cplx_wrap_chk #(
  parameter int WORD_W     = 32,
  parameter int RUN_CYCLES = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              resultValid,
  input logic [WORD_W-1:0] result,
  input logic              inRun
);

  localparam int CW = $clog2(RUN_CYCLES + 2) + 1;
  logic [CW-1:0] runSeen;

  // consecutive cycles spent computing before the current one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runSeen <= '0;
    else if (inRun) runSeen <= runSeen + CW'(1);
    else runSeen <= '0;
  end

  // R5: response lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R5: done and result-valid travel together
  a_r5_done_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    done == resultValid);

  // R5: result bus quiet outside the response
  a_r5_result_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> (result == '0));

  // R3: every response follows exactly RUN_CYCLES engine cycles
  a_r3_run_length: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (runSeen == CW'(RUN_CYCLES)));

  // R9: engine keeps running until the response, never cut short
  a_r9_no_abort: assert property (@(posedge clk) disable iff (!rstN)
    (inRun && (runSeen < CW'(RUN_CYCLES - 1))) |=> inRun);

endmodule

bind cplx_wrap_top cplx_wrap_chk #(.WORD_W(WORD_W), .RUN_CYCLES(RUN_CYCLES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .done       (done),
  .resultValid(resultValid),
  .result     (result),
  .inRun      (ctlInRun)
);

// File: tb/sim_cplx_wrap_top.sv
`timescale 1ns/1ps
module sim_cplx_wrap_top;

  localparam int WORD_W     = 32;
  localparam int RUN_CYCLES = 3;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrValid = 1'b0, opAValid = 1'b0, opBValid = 1'b0;
  logic [WORD_W-1:0] opA = '0, opB = '0;
  logic done, resultValid;
  logic [WORD_W-1:0] result;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  cplx_wrap_top #(.WORD_W(WORD_W), .RUN_CYCLES(RUN_CYCLES)) u0 (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .opAValid(opAValid),
    .opA(opA), .opBValid(opBValid), .opB(opB), .done(done),
    .resultValid(resultValid), .result(result)
  );

  function automatic logic [31:0] cmulRef(logic [31:0] a, logic [31:0] b);
    logic signed [31:0] ar, ai, br, bi, re, im;
    ar = 32'(signed'(a[31:16])); ai = 32'(signed'(a[15:0]));
    br = 32'(signed'(b[31:16])); bi = 32'(signed'(b[15:0]));
    re = ar * br - ai * bi;
    im = ar * bi + ai * br;
    return {re[15:0], im[15:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkQuiet(string req);
    check(req, {31'd0, resultValid}, 32'd0);
    check(req, {31'd0, done}, 32'd0);
    check(req, result, 32'd0);
  endtask

  task automatic driveNoise();
    instrValid = 1'($urandom); opAValid = 1'($urandom);
    opBValid = 1'($urandom); opA = $urandom; opB = $urandom;
  endtask

  // idle cycles; noisy ones carry lone opB / instr without opA (R7, R8)
  task automatic idle(int n, bit noisy);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      instrValid = noisy ? 1'($urandom) : 1'b0;
      opAValid = 1'b0;
      opBValid = noisy ? 1'($urandom) : 1'b0;
      opA = $urandom; opB = $urandom;
      @(posedge clk); #2;
      checkQuiet("R7/R8 idle ignore");
    end
  endtask

  // one instruction; calling it right after another chains it (R6)
  task automatic runReq(logic [31:0] a, logic [31:0] b, bit split, int gap);
    @(negedge clk);
    instrValid = 1'b1; opAValid = 1'b1; opA = a;
    opBValid = !split; opB = split ? $urandom : b;
    if (split) begin
      @(posedge clk); #2;
      checkQuiet("R4 wait for B");
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        instrValid = 1'($urandom); opAValid = 1'($urandom);
        opA = $urandom; opBValid = 1'b0; opB = $urandom;
        @(posedge clk); #2;
        checkQuiet("R4 wait for B");
      end
      @(negedge clk);
      instrValid = 1'b0; opAValid = 1'b0; opA = $urandom;
      opBValid = 1'b1; opB = b;
    end
    @(posedge clk);
    for (int i = 1; i <= RUN_CYCLES; i++) begin
      @(negedge clk);
      driveNoise();  // R9: ignored while running
      @(posedge clk); #2;
      if (i < RUN_CYCLES) checkQuiet("R3 no early response");
      else begin
        check("R5 resultValid", {31'd0, resultValid}, 32'd1);
        check("R5 done", {31'd0, done}, 32'd1);
        check("R2 result", result, cmulRef(a, b));
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        nFail++;
        $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(posedge clk);
    #2 checkQuiet("R1 in reset");
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2 checkQuiet("R1 after reset");

    // directed
    runReq(32'h0003_0002, 32'h0004_FFFF, 1'b0, 0);      // R2 R3
    idle(2, 1'b0);
    runReq(32'h8000_8000, 32'h8000_8000, 1'b0, 0);      // R2 extreme
    idle(1, 1'b0);
    runReq(32'h7FFF_0001, 32'h0002_7FFF, 1'b1, 0);      // R4 split, no gap
    idle(1, 1'b0);
    runReq(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 3);      // R4 split, gap
    runReq(32'h0001_0001, 32'h0001_FFFF, 1'b0, 0);      // R6 chained
    runReq(32'hFFFF_FFFF, 32'h0005_0006, 1'b1, 1);      // R6 chained split
    idle(6, 1'b1);                                      // R7 R8
    runReq(32'h0010_0020, 32'h0030_0040, 1'b1, 2);      // R7 B from its own wait

    // R1: reset during a computation discards it
    @(negedge clk);
    instrValid = 1'b1; opAValid = 1'b1; opBValid = 1'b1;
    opA = 32'h0101_0202; opB = 32'h0303_0404;
    @(posedge clk);
    @(negedge clk);
    instrValid = 1'b0; opAValid = 1'b0; opBValid = 1'b0;
    rstN = 1'b0;
    @(posedge clk); #2 checkQuiet("R1 mid-run reset");
    @(negedge clk); rstN = 1'b1;
    idle(RUN_CYCLES + 2, 1'b0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if ($urandom_range(1, 0) == 1) idle(int'($urandom_range(3, 1)), 1'($urandom));
      runReq(a, b, 1'($urandom), int'($urandom_range(3, 0)));
    end
    idle(4, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule